// File: doc/BRIEF.md
# Scalar Single-Precision Minimum Unit

This datapath takes two 128-bit vector operands, treats only the least significant 32-bit lane of each as an IEEE-754 single-precision number, and writes the smaller of the two into the low lane of a 128-bit result. The three upper lanes of the result are copied from the first operand. The block is meant to sit in a floating-point execution pipe behind operand read. Decode, memory fetch, trap delivery and flag writeback happen elsewhere.

The selection is deliberately asymmetric. If both low lanes are zeros of any sign, or if either low lane is a NaN, the second operand's low lane is returned bit for bit. A NaN on either side always raises an invalid-operation indication. When the invalid exception is unmasked, a NaN raises a fault instead of a valid result, so the destination is never written. With the default `REGISTERED = 1`, one operation is accepted per cycle and its result and flags appear one clock later. With `REGISTERED = 0`, the path is purely combinational.

Top module: `sfmin_unit`

## Requirements
- R1: Result bits 127:32 always equal bits 127:32 of `src_a`, whatever the low lanes hold.
- R2: For two positive, ordered, non-zero low lanes, result bits 31:0 hold the numerically smaller value (for example 1.0 = 0x3F800000 beats 2.0 = 0x40000000).
- R3: When the low lanes differ in sign and are not both zero, the negative one is returned, including negative infinity (0xFF800000) against any positive value.
- R4: When both low lanes are negative, the one with the larger magnitude is returned (-2.0 = 0xC0000000 beats -1.0 = 0xBF800000).
- R5: Denormals are compared by their raw encoding with no flush to zero. For example, +0x00000002 loses to +0x00000001, +0 (0x00000000) beats +0x00000001, and -0x80000001 beats +0x00000000.
- R6: When both low lanes are zero (+0 is 0x00000000, -0 is 0x80000000) in any sign combination, result bits 31:0 equal `src_b` bits 31:0 exactly. Equal non-zero values also return `src_b`.
- R7: A NaN is an exponent field of 0xFF with a non-zero fraction. Bit 22 set means quiet and bit 22 clear means signaling. Infinity (fraction zero) is not a NaN. With `inv_mask` = 1 and a NaN in either low lane, `out_valid` = 1, `invalid` = 1, `fault` = 0, and result bits 31:0 equal `src_b` bits 31:0 exactly.
- R8: `invalid` is 1 for an accepted operation exactly when either low lane is a NaN of either kind, whatever the value of `inv_mask`.
- R9: With `inv_mask` = 0 and a NaN in either low lane, `fault` = 1 and `out_valid` = 0.
- R10: With `REGISTERED = 1`, an operation presented with `in_valid` = 1 on one rising edge produces its result and flags after that edge. Operations on back-to-back cycles each produce their own result. A cycle with `in_valid` = 0 leaves `out_valid`, `invalid` and `fault` at 0. During reset all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the registered variant) |
| rst_n | input | 1 | Active-low synchronous reset of the output flags |
| in_valid | input | 1 | Operation present on the operand inputs |
| src_a | input | 128 | First operand; its upper lanes pass to the result |
| src_b | input | 128 | Second operand; only its low lane is used |
| inv_mask | input | 1 | 1 = invalid-operation exception masked |
| out_valid | output | 1 | Result is to be written to the destination |
| result | output | 128 | Upper lanes from src_a, low lane the selected minimum |
| invalid | output | 1 | A NaN was seen in either low lane |
| fault | output | 1 | Unmasked invalid operation; destination suppressed |

## Verification
A fault in the sign-magnitude ordering shows up at the ports as the wrong low lane on the very next result. It is only visible for particular sign and magnitude combinations, so the negative, mixed-sign, denormal and infinity pairs are each exercised separately. A classification fault, such as treating infinity as a NaN or missing a signaling NaN, shows up on the same cycle as a wrong `invalid`, `fault` or `out_valid`. A lost or extra pipeline stage shifts every result by one cycle, which the back-to-back sequence exposes immediately.

// File: rtl/sfmin_pkg.sv
package sfmin_pkg;

   // Per-operand classification used by the selection policy
   typedef struct packed {
      logic is_nan;
      logic is_zero;
   } sfmin_class_t;

endpackage

// File: rtl/sfmin_classify.sv
module sfmin_classify
   import sfmin_pkg::*;
#(
   parameter int EXP_W = 8,
   parameter int MAN_W = 23
) (
   input  logic [EXP_W+MAN_W:0] lane,
   output sfmin_class_t         cls
);
   localparam int LANE_W = 1 + EXP_W + MAN_W;

   logic [EXP_W-1:0] expo;
   logic [MAN_W-1:0] frac;

   assign expo = lane[LANE_W-2:MAN_W];
   assign frac = lane[MAN_W-1:0];

   always_comb begin
      cls.is_nan  = (&expo) && (|frac);
      cls.is_zero = ~|lane[LANE_W-2:0];
   end

   // R7
   always_comb begin
      if ((&expo) && !(|frac)) begin
         inf_not_nan_chk: assert (!cls.is_nan);
      end
   end
endmodule

// File: rtl/sfmin_order.sv
module sfmin_order #(
   parameter int LANE_W = 32
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic              a_lt_b
);
   logic              sgn_a, sgn_b;
   logic [LANE_W-2:0] mag_a, mag_b;

   assign sgn_a = lane_a[LANE_W-1];
   assign sgn_b = lane_b[LANE_W-1];
   assign mag_a = lane_a[LANE_W-2:0];
   assign mag_b = lane_b[LANE_W-2:0];

   // Sign-magnitude ordering on raw bits; denormals need no special case
   always_comb begin
      if (sgn_a != sgn_b)
         a_lt_b = sgn_a;
      else if (sgn_a)
         a_lt_b = mag_a > mag_b;
      else
         a_lt_b = mag_a < mag_b;
   end

   // R4
   always_comb begin
      if (sgn_a && sgn_b && (mag_a == mag_b)) begin
         neg_equal_chk: assert (!a_lt_b);
      end
   end
endmodule

// File: rtl/sfmin_select.sv
module sfmin_select
   import sfmin_pkg::*;
#(
   parameter int LANE_W = 32
) (
   input  sfmin_class_t      cls_a,
   input  sfmin_class_t      cls_b,
   input  logic              a_lt_b,
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output logic [LANE_W-1:0] lane_out,
   output logic              nan_seen
);
   logic pick_a;

   assign nan_seen = cls_a.is_nan | cls_b.is_nan;
   assign pick_a   = !nan_seen && !(cls_a.is_zero && cls_b.is_zero) && a_lt_b;
   assign lane_out = pick_a ? lane_a : lane_b;

   // R6
   always_comb begin
      if (cls_a.is_zero && cls_b.is_zero) begin
         zero_pair_chk: assert (lane_out == lane_b);
      end
   end
endmodule

// File: rtl/sfmin_unit.sv
module sfmin_unit
   import sfmin_pkg::*;
#(
   parameter int VEC_W      = 128,
   parameter int EXP_W      = 8,
   parameter int MAN_W      = 23,
   parameter bit REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [127:0]     src_a,
   input  logic [127:0]     src_b,
   input  logic             inv_mask,
   output logic             out_valid,
   output logic [127:0]     result,
   output logic             invalid,
   output logic             fault
);
   localparam int LANE_W = 1 + EXP_W + MAN_W;
   localparam int N_OPS  = 2;

   if (VEC_W != 128) begin : g_bad_vec
      $fatal(1, "sfmin_unit: VEC_W must match the 128-bit ports");
   end
   if ((VEC_W % LANE_W) != 0 || LANE_W >= VEC_W) begin : g_bad_lane
      $fatal(1, "sfmin_unit: lane width must divide VEC_W and be smaller");
   end

   logic [LANE_W-1:0] lanes [N_OPS];
   sfmin_class_t      cls   [N_OPS];

   assign lanes[0] = src_a[LANE_W-1:0];
   assign lanes[1] = src_b[LANE_W-1:0];

   for (genvar i = 0; i < N_OPS; i++) begin : g_cls
      sfmin_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
         .lane (lanes[i]),
         .cls  (cls[i])
      );
   end

   logic a_lt_b;
   sfmin_order #(.LANE_W(LANE_W)) u_order (
      .lane_a (lanes[0]),
      .lane_b (lanes[1]),
      .a_lt_b (a_lt_b)
   );

   logic [LANE_W-1:0] lane_min;
   logic              nan_seen;
   sfmin_select #(.LANE_W(LANE_W)) u_sel (
      .cls_a    (cls[0]),
      .cls_b    (cls[1]),
      .a_lt_b   (a_lt_b),
      .lane_a   (lanes[0]),
      .lane_b   (lanes[1]),
      .lane_out (lane_min),
      .nan_seen (nan_seen)
   );

   logic [VEC_W-1:0] res_c;
   logic             valid_c, invalid_c, fault_c;

   assign res_c     = {src_a[VEC_W-1:LANE_W], lane_min};
   assign invalid_c = in_valid & nan_seen;
   assign fault_c   = invalid_c & ~inv_mask;
   assign valid_c   = in_valid & ~fault_c;

   if (REGISTERED) begin : g_reg
      logic [VEC_W-1:0] res_q;
      logic             valid_q, invalid_q, fault_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q   <= 1'b0;
            invalid_q <= 1'b0;
            fault_q   <= 1'b0;
         end else begin
            valid_q   <= valid_c;
            invalid_q <= invalid_c;
            fault_q   <= fault_c;
         end
      end

      always_ff @(posedge clk) begin
         if (in_valid) res_q <= res_c;
      end

      assign out_valid = valid_q;
      assign invalid   = invalid_q;
      assign fault     = fault_q;
      assign result    = res_q;

      // R1
      upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> (result[VEC_W-1:LANE_W] == $past(src_a[VEC_W-1:LANE_W])));

      // R9
      fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
         fault |-> (!out_valid && invalid));

      // R7
      nan_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && inv_mask && nan_seen) |=>
            (out_valid && (result[LANE_W-1:0] == $past(src_b[LANE_W-1:0]))));

      // R10
      idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> (!out_valid && !invalid && !fault));

      // R8
      invalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && (cls[0].is_nan || cls[1].is_nan)) |=> invalid);
   end else begin : g_comb
      assign out_valid = valid_c;
      assign invalid   = invalid_c;
      assign fault     = fault_c;
      assign result    = res_c;

      // R9
      always_comb begin
         if (fault) begin
            fault_excl_chk: assert (!out_valid);
         end
      end
   end
endmodule

// File: tb/sfmin_unit_test.sv
module sfmin_unit_test;
   localparam time CLK_PERIOD = 10ns;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [127:0] src_a, src_b;
   logic         inv_mask;
   logic         out_valid, invalid, fault;
   logic [127:0] result;

   int checks   = 0;
   int failures = 0;

   localparam logic [95:0] UP_A = 96'hA5A5_0123_4567_89AB_CDEF_5A5A;
   localparam logic [95:0] UP_B = 96'h1111_2222_3333_4444_5555_6666;

   localparam logic [31:0] P1   = 32'h3F80_0000;
   localparam logic [31:0] P2   = 32'h4000_0000;
   localparam logic [31:0] N1   = 32'hBF80_0000;
   localparam logic [31:0] N2   = 32'hC000_0000;
   localparam logic [31:0] PZ   = 32'h0000_0000;
   localparam logic [31:0] NZ   = 32'h8000_0000;
   localparam logic [31:0] QNAN = 32'h7FC0_0000;
   localparam logic [31:0] SNAN = 32'h7F80_0001;
   localparam logic [31:0] PINF = 32'h7F80_0000;
   localparam logic [31:0] NINF = 32'hFF80_0000;

   sfmin_unit uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .src_a     (src_a),
      .src_b     (src_b),
      .inv_mask  (inv_mask),
      .out_valid (out_valid),
      .result    (result),
      .invalid   (invalid),
      .fault     (fault)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic m);
      in_valid = 1'b1;
      src_a    = {UP_A, a};
      src_b    = {UP_B, b};
      inv_mask = m;
   endtask

   // one operation: drive at a falling edge, sample at the next falling edge
   task automatic run(input string tag, input logic [31:0] a, input logic [31:0] b,
                      input logic m, input logic [31:0] exp_lo,
                      input logic exp_v, input logic exp_i, input logic exp_f);
      @(negedge clk);
      drive(a, b, m);
      @(negedge clk);
      in_valid = 1'b0;
      chk({tag, " flags"}, {125'd0, out_valid, invalid, fault}, {125'd0, exp_v, exp_i, exp_f});
      if (exp_v) chk({tag, " result"}, result, {UP_A, exp_lo});
   endtask

   task automatic t_reset;
      chk("R10 reset flags", {125'd0, out_valid, invalid, fault}, 128'd0);
   endtask

   task automatic t_positive;
      run("R2 1<2", P1, P2, 1'b1, P1, 1'b1, 1'b0, 1'b0);
      run("R2 2>1", P2, P1, 1'b1, P1, 1'b1, 1'b0, 1'b0);
      run("R1 upper lanes", P2, P2, 1'b1, P2, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_mixed_sign;
      run("R3 -1 vs 2", N1, P2, 1'b1, N1, 1'b1, 1'b0, 1'b0);
      run("R3 2 vs -1", P2, N1, 1'b1, N1, 1'b1, 1'b0, 1'b0);
      run("R3 -inf vs +inf", PINF, NINF, 1'b1, NINF, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_negatives;
      run("R4 -1 vs -2", N1, N2, 1'b1, N2, 1'b1, 1'b0, 1'b0);
      run("R4 -2 vs -1", N2, N1, 1'b1, N2, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_denormals;
      run("R5 dn2 vs dn1", 32'h0000_0002, 32'h0000_0001, 1'b1, 32'h0000_0001, 1'b1, 1'b0, 1'b0);
      run("R5 dn1 vs +0", 32'h0000_0001, PZ, 1'b1, PZ, 1'b1, 1'b0, 1'b0);
      run("R5 -dn vs +0", 32'h8000_0001, PZ, 1'b1, 32'h8000_0001, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_zeros;
      run("R6 +0,-0", PZ, NZ, 1'b1, NZ, 1'b1, 1'b0, 1'b0);
      run("R6 -0,+0", NZ, PZ, 1'b1, PZ, 1'b1, 1'b0, 1'b0);
      run("R6 -0,-0", NZ, NZ, 1'b1, NZ, 1'b1, 1'b0, 1'b0);
      run("R6 equal", N1, 32'hBF80_0000, 1'b1, N1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_nan_masked;
      run("R7 qnan in a", QNAN, P1, 1'b1, P1, 1'b1, 1'b1, 1'b0);
      run("R7 snan in b", N2, SNAN, 1'b1, SNAN, 1'b1, 1'b1, 1'b0);
      run("R7 two nans", SNAN, 32'hFFC0_0001, 1'b1, 32'hFFC0_0001, 1'b1, 1'b1, 1'b0);
      run("R8 inf is not nan", PINF, P1, 1'b1, P1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_nan_unmasked;
      run("R9 snan in a", SNAN, P1, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
      run("R9 qnan in b", P1, QNAN, 1'b0, 32'h0, 1'b0, 1'b1, 1'b1);
      run("R8 no nan unmasked", N1, P1, 1'b0, N1, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic t_pipeline;
      @(negedge clk);
      drive(P2, P1, 1'b1);
      @(negedge clk);
      chk("R10 pipe op0", result, {UP_A, P1});
      drive(N1, N2, 1'b1);
      @(negedge clk);
      chk("R10 pipe op1", result, {UP_A, N2});
      drive(QNAN, N1, 1'b0);
      @(negedge clk);
      chk("R10 pipe op2 flags", {125'd0, out_valid, invalid, fault}, {125'd0, 3'b011});
      in_valid = 1'b0;
      @(negedge clk);
      chk("R10 idle flags", {125'd0, out_valid, invalid, fault}, 128'd0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      src_a    = '0;
      src_b    = '0;
      inv_mask = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_positive();
      t_mixed_sign();
      t_negatives();
      t_denormals();
      t_zeros();
      t_nan_masked();
      t_nan_unmasked();
      t_pipeline();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule